// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that keeps the configuration byte image for a bank of differential clock output pairs. A system clock, much faster than the serial bus, oversamples the serial clock and data lines. The slave answers only to the address picked by a strap input. It pulls the data line low through an open-drain enable and never drives it high. It carries out byte writes, byte reads, counted block writes and block reads. It holds no data path of its own and never stretches the serial clock, so the bus master alone sets the pace.

The command byte that follows the address does three jobs. Its top bit picks single-byte or block access. Its next two bits must match a pattern set by a chip-select strap. Its low five bits give the register offset for single-byte access. Only offsets 22 and 23 hold storage. Their bits drive twelve pair enables, two feedback-output disables and a two-bit input threshold code as plain control pins.

Top module: `smb_cfg_regs`

## Requirements
- R1: After reset all twelve pair enables are 1, both feedback disables are 0, the threshold code is 00 and the slave does not pull the data line.
- R2: The slave acknowledges an address byte only when its upper seven bits are 1101001 with `addr_sel_i`=1, or 1101110 with `addr_sel_i`=0. Any other address gets no acknowledge, and the transfer that follows changes nothing.
- R3: Command bits 6:5 must be 01 when `chip_sel_i`=0 and 10 when `chip_sel_i`=1. A command with any other pattern gets no acknowledge and changes no register.
- R4: A byte write (command bit 7 = 1, bits 4:0 = offset, then one data byte) stores the byte at that offset. Offset 23 drives `pair_en_o[7:0]`. Offset 22 bits 7:6 drive `thresh_o`, bit 5 drives `fb_dis_o[1]`, bit 4 drives `fb_dis_o[0]`, and bits 3:0 drive `pair_en_o[11:8]`.
- R5: A byte read (command, repeated start, read address) returns the register at the offset, most significant bit first. Offsets other than 22 and 23 read as 0 and ignore writes.
- R6: A block write (command bit 7 = 0, bits 4:0 = 00000, then a count byte and data bytes) fills registers from offset 0 upward. Every byte is acknowledged. Data bytes past the count, or past offset 23, are discarded. A block command with a nonzero offset is not acknowledged.
- R7: A block read returns the count 24 and then registers 0 to 23 in order. A not-acknowledge from the master ends the transfer and releases the line.
- R8: A read address that is not preceded in the same transfer by an acknowledged command is not acknowledged.
- R9: A stop or start condition clears the bit and byte position. An unfinished data byte is never written.
- R10: The slave changes its data-line drive only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 1 | Strap that selects one of two slave addresses |
| chip_sel_i | input | 1 | Strap that selects the required command bits 6:5 |
| pair_en_o | output | 12 | Enables of the differential output pairs |
| fb_dis_o | output | 2 | Feedback output disables, [1] output A, [0] output B |
| thresh_o | output | 2 | Input threshold code |

## Verification
Directed transfers cover each strap setting, wrong addresses, wrong chip-select patterns and block commands with a nonzero offset. Each of these separates a correct acknowledge decision from a slave that answers too freely. Block writes are tried with an exact count, with more bytes sent than counted and with a count running past the last register, which separates correct discard behaviour from overrun. A transfer aborted by a stop in the middle of a byte shows whether partial data can leak into a register. Seeded random byte writes and reads to implemented, unimplemented and out-of-range offsets, under changing straps, are compared with a bench model of the two bytes. A monitor also watches every change of the data-line drive against the serial clock level.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_POSTCMD,
    ST_WDATA,
    ST_RDATA
  } smb_state_e;

  localparam int REG_COUNT = 24;
  localparam int OFS_W = 5;
  localparam logic [6:0] DEV_ADDR_HI = 7'b1101001;
  localparam logic [6:0] DEV_ADDR_LO = 7'b1101110;
  localparam logic [1:0] CS_PAT_LO = 2'b01;
  localparam logic [1:0] CS_PAT_HI = 2'b10;
  localparam logic [OFS_W-1:0] IDX_MISC = 5'd22;
  localparam logic [OFS_W-1:0] IDX_PAIR = 5'd23;
  localparam logic [7:0] MISC_RST = 8'b0000_1111;
  localparam logic [7:0] PAIR_RST = 8'hFF;
  localparam logic [7:0] BLOCK_LEN = 8'(REG_COUNT);
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/smb_cond.sv
module smb_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_cfg_pkg::*;
#(
  parameter int NPAIR = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFS_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [OFS_W-1:0] raddr,
  output logic [7:0]       rdata,
  output logic [NPAIR-1:0] pair_en,
  output logic [1:0]       fb_dis,
  output logic [1:0]       thresh
);
  localparam int HI_PAIRS = NPAIR - 8;

  logic [7:0] misc_q, pair_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q <= MISC_RST;
      pair_q <= PAIR_RST;
    end else if (we) begin
      if (waddr == IDX_MISC) misc_q <= wdata;
      if (waddr == IDX_PAIR) pair_q <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (raddr == IDX_MISC) rdata = misc_q;
    if (raddr == IDX_PAIR) rdata = pair_q;
  end

  assign pair_en = {misc_q[HI_PAIRS-1:0], pair_q};
  assign fb_dis  = misc_q[5:4];
  assign thresh  = misc_q[7:6];

  // R1
  rst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pair_en == '1 && fb_dis == 2'b00 && thresh == 2'b00));

  // R5
  ign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != IDX_MISC && waddr != IDX_PAIR) |=> $stable({misc_q, pair_q}));
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             sda_s,
  input  logic             addr_sel,
  input  logic             chip_sel,
  output logic             sda_oe,
  output logic             we,
  output logic [OFS_W-1:0] waddr,
  output logic [7:0]       wdata,
  output logic [OFS_W-1:0] raddr,
  input  logic [7:0]       rdata
);
  smb_state_e       state;
  logic [3:0]       bitcnt;
  logic             in_ack;
  logic             ack_drive;
  logic [7:0]       shreg;
  logic             blk_mode;
  logic [OFS_W-1:0] offset;
  logic [OFS_W-1:0] ptr;
  logic [7:0]       wr_left;
  logic             cnt_pending;
  logic             rd_ok;
  logic             mnack;

  logic [6:0]       my_addr;
  logic [1:0]       cs_pat;
  logic             cmd_ok;
  logic             addr_hit;
  logic             enter_ack;
  logic             leave_ack;
  logic [OFS_W-1:0] ptr_inc;

  assign my_addr   = addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO;
  assign cs_pat    = chip_sel ? CS_PAT_HI : CS_PAT_LO;
  assign cmd_ok    = (shreg[6:5] == cs_pat) && (shreg[7] || shreg[4:0] == '0);
  assign addr_hit  = (shreg[7:1] == my_addr);
  assign enter_ack = scl_fall && !in_ack && bitcnt == 4'd8;
  assign leave_ack = scl_fall && in_ack;
  assign ptr_inc   = (ptr == '1) ? ptr : ptr + 1'b1;

  assign we    = enter_ack && !start_evt && !stop_evt &&
                 ((state == ST_POSTCMD && !blk_mode) || (state == ST_WDATA && wr_left != 8'd0));
  assign waddr = (state == ST_POSTCMD) ? offset : ptr;
  assign wdata = shreg;
  assign raddr = ptr;

  assign sda_oe = in_ack ? ack_drive : (state == ST_RDATA && !shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      in_ack      <= 1'b0;
      ack_drive   <= 1'b0;
      shreg       <= 8'hFF;
      blk_mode    <= 1'b0;
      offset      <= '0;
      ptr         <= '0;
      wr_left     <= '0;
      cnt_pending <= 1'b0;
      rd_ok       <= 1'b0;
      mnack       <= 1'b0;
    end else if (stop_evt) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      in_ack    <= 1'b0;
      ack_drive <= 1'b0;
      rd_ok     <= 1'b0;
    end else if (start_evt) begin
      state     <= ST_ADDR;
      bitcnt    <= '0;
      in_ack    <= 1'b0;
      ack_drive <= 1'b0;
      rd_ok     <= (state == ST_POSTCMD) && !in_ack;
    end else if (scl_rise) begin
      if (in_ack) begin
        if (state == ST_RDATA) mnack <= sda_s;
      end else if (bitcnt != 4'd8) begin
        if (state != ST_RDATA) shreg <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end
    end else if (enter_ack) begin
      in_ack    <= 1'b1;
      ack_drive <= 1'b0;
      unique case (state)
        ST_ADDR: begin
          if (addr_hit && !shreg[0]) begin
            ack_drive <= 1'b1;
            state     <= ST_CMD;
          end else if (addr_hit && rd_ok) begin
            ack_drive   <= 1'b1;
            state       <= ST_RDATA;
            ptr         <= blk_mode ? '0 : offset;
            cnt_pending <= blk_mode;
            mnack       <= 1'b0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_CMD: begin
          if (cmd_ok) begin
            ack_drive <= 1'b1;
            blk_mode  <= ~shreg[7];
            offset    <= shreg[4:0];
            state     <= ST_POSTCMD;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_POSTCMD: begin
          ack_drive <= 1'b1;
          ptr       <= '0;
          wr_left   <= blk_mode ? shreg : 8'd0;
          state     <= ST_WDATA;
        end
        ST_WDATA: begin
          ack_drive <= 1'b1;
          if (wr_left != 8'd0) begin
            wr_left <= wr_left - 8'd1;
            ptr     <= ptr_inc;
          end
        end
        default: ack_drive <= 1'b0;
      endcase
    end else if (leave_ack) begin
      in_ack    <= 1'b0;
      bitcnt    <= '0;
      ack_drive <= 1'b0;
      if (state == ST_RDATA) begin
        if (mnack) begin
          state <= ST_IDLE;
        end else begin
          cnt_pending <= 1'b0;
          if (cnt_pending) begin
            shreg <= BLOCK_LEN;
          end else begin
            shreg <= rdata;
            ptr   <= ptr_inc;
          end
        end
      end
    end else if (scl_fall && state == ST_RDATA && bitcnt != 4'd0) begin
      shreg <= {shreg[6:0], 1'b1};
    end
  end

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_fall) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe));

  // R6
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (in_ack && sda_oe));

  // R9
  frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> (!in_ack && !we));
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NPAIR = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             addr_sel_i,
  input  logic             chip_sel_i,
  output logic [NPAIR-1:0] pair_en_o,
  output logic [1:0]       fb_dis_o,
  output logic [1:0]       thresh_o
);
  logic [1:0]       line_s;
  logic             scl_rise, scl_fall, start_evt, stop_evt;
  logic             we;
  logic [OFS_W-1:0] waddr, raddr;
  logic [7:0]       wdata, rdata;

  smb_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  smb_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  smb_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_s     (line_s[0]),
    .addr_sel  (addr_sel_i),
    .chip_sel  (chip_sel_i),
    .sda_oe    (sda_oe_o),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata),
    .raddr     (raddr),
    .rdata     (rdata)
  );

  smb_regbank #(.NPAIR(NPAIR)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata),
    .raddr   (raddr),
    .rdata   (rdata),
    .pair_en (pair_en_o),
    .fb_dis  (fb_dis_o),
    .thresh  (thresh_o)
  );
endmodule

// File: tb/smb_cfg_regs_tb.sv
module smb_cfg_regs_tb;
  localparam int CLK_NS = 10;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b1;
  logic chip_sel = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [11:0] pair_en;
  logic [1:0] fb_dis, thresh;

  int checks = 0;
  int fails = 0;
  int viol = 0;
  bit done = 1'b0;
  logic [7:0] model [32];
  logic [7:0] blk_buf [32];
  logic [7:0] rd_buf [24];

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_NS/2) clk = ~clk;

  smb_cfg_regs u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .addr_sel_i (addr_sel),
    .chip_sel_i (chip_sel),
    .pair_en_o  (pair_en),
    .fb_dis_o   (fb_dis),
    .thresh_o   (thresh)
  );

  // R10 monitor: drive may change only while SCL is low
  logic scl_p = 1'b1, oe_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_p && sda_oe != oe_p) viol++;
    scl_p = scl;
    oe_p = sda_oe;
  end

  function automatic logic [6:0] dev_addr(input logic sel);
    return sel ? 7'b1101001 : 7'b1101110;
  endfunction

  function automatic logic [7:0] cmd_byte(input logic blk, input logic cs, input logic [4:0] ofs);
    return {~blk, (cs ? 2'b10 : 2'b01), ofs};
  endfunction

  function automatic logic [15:0] exp_image();
    return {model[22], model[23]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    b = sda_bus; wq();
    scl = 1'b0; wq();
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) m_wbit(b[i]);
    m_rbit(a);
    ack = ~a;
  endtask

  task automatic m_rbyte(input logic nack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(x);
      b[i] = x;
    end
    m_wbit(nack);
  endtask

  task automatic tx_bw(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                       output logic [2:0] acks);
    m_start();
    m_wbyte({a, 1'b0}, acks[2]);
    m_wbyte(cmd, acks[1]);
    m_wbyte(d, acks[0]);
    m_stop();
  endtask

  task automatic tx_br(input logic [6:0] a, input logic [7:0] cmd, output logic [7:0] d,
                       output logic [2:0] acks);
    m_start();
    m_wbyte({a, 1'b0}, acks[2]);
    m_wbyte(cmd, acks[1]);
    m_start();
    m_wbyte({a, 1'b1}, acks[0]);
    m_rbyte(1'b1, d);
    m_stop();
  endtask

  task automatic tx_blkw(input logic [7:0] count, input int nsend, output logic allack);
    logic k;
    allack = 1'b1;
    m_start();
    m_wbyte({dev_addr(addr_sel), 1'b0}, k); allack &= k;
    m_wbyte(cmd_byte(1'b1, chip_sel, 5'd0), k); allack &= k;
    m_wbyte(count, k); allack &= k;
    for (int i = 0; i < nsend; i++) begin
      m_wbyte(blk_buf[i], k);
      allack &= k;
    end
    m_stop();
  endtask

  task automatic tx_blkr(output logic [7:0] cnt, output logic allack);
    logic k;
    logic [7:0] b;
    allack = 1'b1;
    m_start();
    m_wbyte({dev_addr(addr_sel), 1'b0}, k); allack &= k;
    m_wbyte(cmd_byte(1'b1, chip_sel, 5'd0), k); allack &= k;
    m_start();
    m_wbyte({dev_addr(addr_sel), 1'b1}, k); allack &= k;
    m_rbyte(1'b0, cnt);
    for (int i = 0; i < 24; i++) begin
      m_rbyte(i == 23, b);
      rd_buf[i] = b;
    end
    m_stop();
  endtask

  task automatic model_write(input logic [4:0] ofs, input logic [7:0] d);
    if (ofs == 5'd22 || ofs == 5'd23) model[ofs] = d;
  endtask

  task automatic finish_run();
    if (viol != 0) begin
      checks++;
      fails++;
      $display("FAIL R10 drive changes with SCL high actual=%0d expected=0", viol);
    end else begin
      checks++;
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d, cnt;
    logic ok;
    void'($urandom(32'd2718));
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    model[22] = 8'h0F;
    model[23] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 image", {thresh, fb_dis, pair_en}, 16'h0FFF);
    chk("R1 sda released", sda_oe, 0);

    // R2 R4 byte write to pair register
    tx_bw(dev_addr(1'b1), cmd_byte(1'b0, 1'b0, 5'd23), 8'hA5, acks);
    model_write(5'd23, 8'hA5);
    chk("R2 R4 acks", acks, 3'b111);
    chk("R4 image", {thresh, fb_dis, pair_en}, exp_image());

    // R5 byte read back
    tx_br(dev_addr(1'b1), cmd_byte(1'b0, 1'b0, 5'd23), d, acks);
    chk("R5 acks", acks, 3'b111);
    chk("R5 data", d, model[23]);

    // R2 wrong address
    tx_bw(7'h55, cmd_byte(1'b0, 1'b0, 5'd23), 8'h00, acks);
    chk("R2 foreign addr nack", acks, 3'b000);
    chk("R2 image kept", {thresh, fb_dis, pair_en}, exp_image());
    tx_bw(dev_addr(1'b0), cmd_byte(1'b0, 1'b0, 5'd23), 8'h00, acks);
    chk("R2 other strap addr nack", acks, 3'b000);

    // R3 chip-select pattern mismatch
    tx_bw(dev_addr(1'b1), cmd_byte(1'b0, 1'b1, 5'd23), 8'h11, acks);
    chk("R3 cmd nack", acks, 3'b100);
    chk("R3 image kept", {thresh, fb_dis, pair_en}, exp_image());
    chip_sel = 1'b1;
    tx_bw(dev_addr(1'b1), cmd_byte(1'b0, 1'b1, 5'd23), 8'h3C, acks);
    model_write(5'd23, 8'h3C);
    chk("R3 cs high acks", acks, 3'b111);
    chk("R3 cs high image", {thresh, fb_dis, pair_en}, exp_image());

    // R4 misc register fields, other address strap
    addr_sel = 1'b0;
    tx_bw(dev_addr(1'b0), cmd_byte(1'b0, 1'b1, 5'd22), 8'hC6, acks);
    model_write(5'd22, 8'hC6);
    chk("R4 misc acks", acks, 3'b111);
    chk("R4 thresh", thresh, 2'b11);
    chk("R4 fb_dis", fb_dis, 2'b00);
    chk("R4 high pairs", pair_en[11:8], 4'h6);

    // R5 unimplemented offset
    tx_bw(dev_addr(1'b0), cmd_byte(1'b0, 1'b1, 5'd5), 8'h77, acks);
    tx_br(dev_addr(1'b0), cmd_byte(1'b0, 1'b1, 5'd5), d, acks);
    chk("R5 unimpl read", d, 8'h00);
    chk("R5 unimpl image", {thresh, fb_dis, pair_en}, exp_image());

    // R6 block write exact count
    for (int i = 0; i < 32; i++) blk_buf[i] = 8'(i * 37 + 11);
    tx_blkw(8'd24, 24, ok);
    model_write(5'd22, blk_buf[22]);
    model_write(5'd23, blk_buf[23]);
    chk("R6 all acked", ok, 1);
    chk("R6 image", {thresh, fb_dis, pair_en}, exp_image());

    // R6 more bytes than count
    for (int i = 0; i < 32; i++) blk_buf[i] = 8'(i * 13 + 90);
    tx_blkw(8'd23, 24, ok);
    model_write(5'd22, blk_buf[22]);
    chk("R6 over count acked", ok, 1);
    chk("R6 over count image", {thresh, fb_dis, pair_en}, exp_image());

    // R6 count past last register
    for (int i = 0; i < 32; i++) blk_buf[i] = 8'(i * 7 + 1);
    tx_blkw(8'd30, 26, ok);
    model_write(5'd22, blk_buf[22]);
    model_write(5'd23, blk_buf[23]);
    chk("R6 past end acked", ok, 1);
    chk("R6 past end image", {thresh, fb_dis, pair_en}, exp_image());

    // R6 block command with nonzero offset
    tx_bw(dev_addr(1'b0), {1'b0, 2'b10, 5'd3}, 8'h00, acks);
    chk("R6 block offset nack", acks, 3'b100);

    // R7 block read
    tx_blkr(cnt, ok);
    chk("R7 acks", ok, 1);
    chk("R7 count", cnt, 8'd24);
    for (int i = 0; i < 24; i++) chk($sformatf("R7 byte %0d", i), rd_buf[i], model[i]);
    chk("R7 line released", sda_oe, 0);

    // R8 read address without command
    m_start();
    m_wbyte({dev_addr(1'b0), 1'b1}, ok);
    m_stop();
    chk("R8 bare read nack", ok, 0);

    // R9 stop inside a data byte
    m_start();
    m_wbyte({dev_addr(1'b0), 1'b0}, ok);
    m_wbyte(cmd_byte(1'b0, 1'b1, 5'd23), ok);
    for (int i = 0; i < 4; i++) m_wbit(1'b0);
    m_stop();
    chk("R9 partial byte dropped", {thresh, fb_dis, pair_en}, exp_image());
    tx_bw(dev_addr(1'b0), cmd_byte(1'b0, 1'b1, 5'd23), 8'h81, acks);
    model_write(5'd23, 8'h81);
    chk("R9 next transfer acks", acks, 3'b111);
    chk("R9 next transfer image", {thresh, fb_dis, pair_en}, exp_image());

    // random byte traffic, R4 R5
    for (int it = 0; it < 30; it++) begin
      logic [4:0] ofs;
      logic [7:0] dat;
      int pick;
      addr_sel = 1'($urandom % 2);
      chip_sel = 1'($urandom % 2);
      pick = int'($urandom % 4);
      ofs = (pick == 0) ? 5'd22 : (pick == 1) ? 5'd23 : 5'($urandom % 32);
      dat = 8'($urandom);
      if ($urandom % 2 == 0) begin
        tx_bw(dev_addr(addr_sel), cmd_byte(1'b0, chip_sel, ofs), dat, acks);
        model_write(ofs, dat);
        chk("R4 random write acks", acks, 3'b111);
        chk("R4 random image", {thresh, fb_dis, pair_en}, exp_image());
      end else begin
        tx_br(dev_addr(addr_sel), cmd_byte(1'b0, chip_sel, ofs), d, acks);
        chk("R5 random read acks", acks, 3'b111);
        chk("R5 random read data", d, model[ofs]);
      end
    end

    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end
endmodule